// File: doc/BRIEF.md
# Blocking Token Send Port with Read-Triggered Handshake

This block lets a hardware actor hand tokens, one at a time, to a processor that fetches them over a memory-mapped register bus, typically by means of a DMA engine. The actor offers a token with `send_valid`. The port latches the token and raises a single ready flag. Until the token is taken, the port accepts nothing new. There is no queue: at most one token is in flight.

The processor side sees two word registers. The token register sits at offset 0. The flag register sits at offset 1 and holds the ready flag in bit 0. Software or the DMA engine polls the flag and then reads the token register. That read completes the transfer. The port drops the flag and pulses `send_done` so that the actor can continue. Reads of the flag register and reads of the token register while no token is pending change nothing.

Top module: `dma_send_port`

## Requirements
- R1: After reset, `send_ready` is 1, `send_done` is 0, `bus_rdata` is 0, and a read of offset 1 returns 0.
- R2: When `send_valid` is high while `send_ready` is high, the port captures `send_data` at that clock edge. From the next cycle on, bit 0 of offset 1 reads 1 and `send_ready` is 0.
- R3: While a token is pending, `send_ready` stays 0 and any `send_valid`/`send_data` activity is ignored. A later read of offset 0 returns the token first captured.
- R4: A read of offset 1 returns the pending flag in bit 0 and zero in bits 15:1. It never changes the flag and never asserts `send_done`.
- R5: A read of offset 0 while a token is pending asserts `send_done` in the strobe cycle and returns the token in `bus_rdata` one cycle later. From the next cycle on, the flag reads 0 and `send_ready` is 1.
- R6: A read of offset 0 while no token is pending returns the last captured token, does not assert `send_done`, and leaves the flag clear.
- R7: `bus_rdata` changes only in the cycle after a cycle with `bus_rd` high, and it holds its value between strobes.
- R8: A read of any offset other than 0 or 1 returns zero and has no effect on the flag or on `send_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_valid | input | 1 | Actor offers a token |
| send_data | input | DATA_W | Token offered by the actor |
| send_ready | output | 1 | Port can accept a token (no token pending) |
| send_done | output | 1 | Pending token was read by the bus this cycle |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Word offset: 0 token, 1 flag |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the strobe |

## Verification
The handshake runs over a sweep of tokens: all-zeros, all-ones, every walking-one and walking-zero pattern, and a set of arithmetic values. A token register that drops or mixes bits therefore shows up. Each round adds a status poll and a conflicting `send_valid` with different data while the token is pending. The same round makes a second token read after completion, which separates a real data read from a stale one and from a status read. A final sweep over the unmapped offsets, both with and without a pending token, shows that only offset 0 completes a transfer.

// File: rtl/dma_send_port.sv
module dma_send_port #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send_valid,
  input  logic [DATA_W-1:0] send_data,
  output logic              send_ready,
  output logic              send_done,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] OFS_TOKEN = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_FLAG  = ADDR_W'(1);

  logic              pending_q;
  logic [DATA_W-1:0] token_q;
  logic [DATA_W-1:0] rdata_q;

  wire load     = send_valid && !pending_q;
  wire rd_token = bus_rd && (bus_addr == OFS_TOKEN);
  wire rd_flag  = bus_rd && (bus_addr == OFS_FLAG);

  assign send_ready = !pending_q;
  assign send_done  = rd_token && pending_q;
  assign bus_rdata  = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      token_q   <= '0;
    end else if (load) begin
      pending_q <= 1'b1;
      token_q   <= send_data;
    end else if (send_done) begin
      pending_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (bus_rd)
      rdata_q <= rd_token ? token_q :
                 rd_flag  ? {{(DATA_W-1){1'b0}}, pending_q} : '0;
  end

  // R2: an accepted offer blocks the port on the next cycle
  a_r2_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (send_valid && send_ready) |=> !send_ready);

  // R3: the held token does not move while pending and not taken
  a_r3_token_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!send_ready && !send_done) |=> ($stable(token_q) && !send_ready));

  // R4: a flag read reports the flag and leaves it alone
  a_r4_flag_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_FLAG && !(send_valid && send_ready))
      |=> (send_ready == $past(send_ready)) &&
          (bus_rdata == {{(DATA_W-1){1'b0}}, !$past(send_ready)}));

  // R5: completion frees the port on the following cycle
  a_r5_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    send_done |=> send_ready);

  // R5: completion only when a token is pending and the token offset is read
  a_r5_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    send_done |-> (!send_ready && bus_rd && bus_addr == OFS_TOKEN));

  // R7: read data holds between strobes
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R8: unmapped offsets read as zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != OFS_TOKEN && bus_addr != OFS_FLAG) |=> (bus_rdata == '0));
endmodule

// File: tb/dma_send_port_bench.sv
module dma_send_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          send_valid = 1'b0;
  logic [DW-1:0] send_data = '0;
  logic          send_ready;
  logic          send_done;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  dma_send_port #(.DATA_W(DW), .ADDR_W(AW)) u_dma_send_port (
    .clk(clk), .rst_n(rst_n), .send_valid(send_valid), .send_data(send_data),
    .send_ready(send_ready), .send_done(send_done), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                          output logic done);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 done = send_done;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic offer(input logic [DW-1:0] v, output logic rdy);
    @(negedge clk);
    send_valid = 1'b1; send_data = v;
    #1 rdy = send_ready;
    @(negedge clk);
    send_valid = 1'b0;
  endtask

  function automatic logic [DW-1:0] pattern(input int i);
    if (i == 0) return '0;
    if (i == 1) return '1;
    if (i < 2 + DW) return DW'(1) << (i - 2);
    if (i < 2 + 2*DW) return ~(DW'(1) << (i - 2 - DW));
    return DW'((i * 16'h3B5D) ^ (i << 7));
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, tok, prev;
    logic dn, rdy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(send_ready == 1'b1, "R1 ready", DW'(send_ready), 1);
    check(send_done == 1'b0, "R1 done", DW'(send_done), 0);
    check(bus_rdata == '0, "R1 rdata", bus_rdata, 0);
    bus_read(AW'(1), d, dn);
    check(d == '0, "R1 flag", d, 0);

    prev = '0;
    for (int i = 0; i < 48; i++) begin
      tok = pattern(i);
      offer(tok, rdy);
      check(rdy == 1'b1, "R2 ready before load", DW'(rdy), 1);
      #1;
      check(send_ready == 1'b0, "R2 blocked", DW'(send_ready), 0);
      bus_read(AW'(1), d, dn);
      check(d == DW'(1), "R4 flag set", d, 1);
      check(dn == 1'b0, "R4 no done", DW'(dn), 0);
      offer(~tok, rdy);
      check(rdy == 1'b0, "R3 ready low", DW'(rdy), 0);
      bus_read(AW'(1), d, dn);
      check(d == DW'(1), "R4 flag kept", d, 1);
      // R7: data holds after strobe ends
      @(negedge clk);
      check(bus_rdata == DW'(1), "R7 hold", bus_rdata, 1);
      bus_read(AW'(0), d, dn);
      check(dn == 1'b1, "R5 done", DW'(dn), 1);
      check(d == tok, "R5 token", d, tok);
      check(send_ready == 1'b1, "R5 ready", DW'(send_ready), 1);
      bus_read(AW'(1), d, dn);
      check(d == '0, "R5 flag clear", d, 0);
      bus_read(AW'(0), d, dn);
      check(dn == 1'b0, "R6 no done", DW'(dn), 0);
      check(d == tok, "R6 stale", d, tok);
      bus_read(AW'(1), d, dn);
      check(d == '0, "R6 flag stays clear", d, 0);
      prev = tok;
    end

    for (int a = 2; a < (1 << AW); a++) begin
      bus_read(AW'(a), d, dn);
      check(d == '0, "R8 unmapped idle", d, 0);
      check(dn == 1'b0, "R8 no done idle", DW'(dn), 0);
      offer(16'hA5C3, rdy);
      bus_read(AW'(a), d, dn);
      check(d == '0, "R8 unmapped pending", d, 0);
      check(dn == 1'b0, "R8 no done pending", DW'(dn), 0);
      bus_read(AW'(1), d, dn);
      check(d == DW'(1), "R8 flag untouched", d, 1);
      bus_read(AW'(0), d, dn);
      check(d == 16'hA5C3 && dn, "R8 token after unmapped", d, 16'hA5C3);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule